// File: doc/BRIEF.md
# Mask-and-Status Interrupt Controller

This block gathers up to 32 interrupt lines for a processor core and drives a single request into it. Each line owns one enable bit in a mask register and one pending bit in a status register. Software reaches both registers through a small register port with one address bit. A read returns the addressed register whole, so a handler can fetch every pending bit at once and scan it from bit 0 upward.

The line-handling style is fixed per build. In edge mode a rising edge sets the pending bit. In level mode the pending bit simply mirrors the line. In latched mode a high level sets the pending bit and the bit stays set until it is acknowledged. The acknowledge polarity is also fixed per build: either a written 1 clears a pending bit, or a written 0 clears it.

Every line passes through a synchroniser before any capture. The request output is registered. A combinational helper output gives the lowest-numbered line that is both pending and enabled, so the handler knows where to start.

Top module: `irq_ms_ctrl`

## Requirements
- R1: After reset the mask register reads 0, the status register reads 0, `irq_req` is 0 and `pend_valid` is 0.
- R2: A write with `reg_addr`=0 loads the mask register. A read with `reg_addr`=0 returns the mask and a read with `reg_addr`=1 returns all pending bits. The mask changes only on a mask write.
- R3: Each line passes through a synchroniser of `SYNC_STAGES` flops (2 by default). With the default depth, a line that is driven high just after a clock edge shows in a latched status bit after the third following edge, and no sooner.
- R4: In edge mode (`LINE_MODE`=TRIG_EDGE) a rising edge on a synchronised line sets its pending bit. The bit stays set after the line goes low, until it is acknowledged.
- R5: In level mode (`LINE_MODE`=TRIG_LEVEL) the pending bit equals the synchronised line, and writes to the status register have no effect.
- R6: In latched mode (`LINE_MODE`=TRIG_LATCH) a high synchronised line sets its pending bit. The bit stays set after the line drops, until it is acknowledged. In edge and latched modes a pending bit never falls except on a status write.
- R7: With `CLEAR_ON_ZERO`=0, writing 1 to a status bit clears it and writing 0 leaves it unchanged.
- R8: With `CLEAR_ON_ZERO`=1, writing 0 to a status bit clears it and writing 1 leaves it unchanged.
- R9: When a set condition and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R10: `irq_req` is the OR over all lines of (status AND mask), delayed by one clock.
- R11: `pend_idx` is the index of the lowest set bit of (status AND mask), and `pend_valid` is 1 exactly when any such bit is set. Both outputs are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| irq_in | input | NUM_LINES | Raw interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the mask register, 1 selects the status register |
| reg_wdata | input | NUM_LINES | Write data |
| reg_rdata | output | NUM_LINES | Read data of the addressed register |
| irq_req | output | 1 | Registered interrupt request to the core |
| pend_valid | output | 1 | Some enabled line is pending |
| pend_idx | output | $clog2(NUM_LINES) | Lowest enabled pending line |

## Verification
The bench builds three copies at once and drives them with the same stimulus: edge mode with clear-on-one, level mode, and latched mode with clear-on-zero. Because they share one status write, a single write shows one polarity clearing a bit while the other leaves it, and shows level mode ignoring the write. The edge build lets a clearing write land on the exact cycle an edge is captured. The latched build holds a line high against a clearing write.

// File: rtl/irq_ms_pkg.sv
package irq_ms_pkg;
    typedef enum logic [1:0] {
        TRIG_EDGE  = 2'd0,
        TRIG_LEVEL = 2'd1,
        TRIG_LATCH = 2'd2
    } trig_mode_e;

    localparam logic ADDR_MASK = 1'b0;
    localparam logic ADDR_STAT = 1'b1;
endpackage

// File: rtl/irq_ms_sync.sv
module irq_ms_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q[0] <= '0;
        else        pipe_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) pipe_q[s] <= '0;
            else        pipe_q[s] <= pipe_q[s-1];
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/irq_ms_status_bank.sv
module irq_ms_status_bank
    import irq_ms_pkg::*;
#(
    parameter int         N             = 32,
    parameter trig_mode_e LINE_MODE     = TRIG_LATCH,
    parameter bit         CLEAR_ON_ZERO = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_in,
    input  logic         wr_stat,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] status
);
    logic [N-1:0] clr_vec;

    // Acknowledge polarity is chosen per build
    always_comb begin
        if (!wr_stat)           clr_vec = '0;
        else if (CLEAR_ON_ZERO) clr_vec = ~wdata;
        else                    clr_vec = wdata;
    end

    if (LINE_MODE == TRIG_LEVEL) begin : g_level
        assign status = line_in;
        logic unused_bank;
        assign unused_bank = ^{clk, rst_n, clr_vec};
    end else begin : g_held
        logic [N-1:0] stat_q;
        logic [N-1:0] set_vec;

        if (LINE_MODE == TRIG_EDGE) begin : g_edge
            logic [N-1:0] prev_q;
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= '0;
                else        prev_q <= line_in;
            end
            assign set_vec = line_in & ~prev_q;
        end else begin : g_lvl_latch
            assign set_vec = line_in;
        end

        // Setting wins over clearing
        always_ff @(posedge clk) begin
            if (!rst_n) stat_q <= '0;
            else        stat_q <= set_vec | (stat_q & ~clr_vec);
        end

        assign status = stat_q;
    end
endmodule

// File: rtl/irq_ms_lowest.sv
module irq_ms_lowest #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             valid
);
    always_comb begin
        idx   = '0;
        valid = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IDX_W'(i);
                valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_ms_ctrl.sv
module irq_ms_ctrl
    import irq_ms_pkg::*;
#(
    parameter int         NUM_LINES     = 32,
    parameter int         SYNC_STAGES   = 2,
    parameter trig_mode_e LINE_MODE     = TRIG_LATCH,
    parameter bit         CLEAR_ON_ZERO = 1'b1,
    localparam int        IDX_W         = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 reg_wr,
    input  logic                 reg_addr,
    input  logic [NUM_LINES-1:0] reg_wdata,
    output logic [NUM_LINES-1:0] reg_rdata,
    output logic                 irq_req,
    output logic                 pend_valid,
    output logic [IDX_W-1:0]     pend_idx
);
    logic [NUM_LINES-1:0] line_sync;
    logic [NUM_LINES-1:0] status_w;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] live_w;
    logic                 wr_mask;
    logic                 wr_stat;
    logic                 req_q;

    assign wr_mask = reg_wr && (reg_addr == ADDR_MASK);
    assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);

    irq_ms_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(irq_in), .q(line_sync)
    );

    irq_ms_status_bank #(
        .N(NUM_LINES), .LINE_MODE(LINE_MODE), .CLEAR_ON_ZERO(CLEAR_ON_ZERO)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .line_in(line_sync),
        .wr_stat(wr_stat), .wdata(reg_wdata), .status(status_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            req_q  <= 1'b0;
        end else begin
            if (wr_mask) mask_q <= reg_wdata;
            req_q <= |live_w;
        end
    end

    assign live_w    = status_w & mask_q;
    assign irq_req   = req_q;
    assign reg_rdata = (reg_addr == ADDR_STAT) ? status_w : mask_q;

    irq_ms_lowest #(.N(NUM_LINES), .IDX_W(IDX_W)) u_pick (
        .vec(live_w), .idx(pend_idx), .valid(pend_valid)
    );
endmodule

// File: rtl/irq_ms_chk.sv
module irq_ms_chk
    import irq_ms_pkg::*;
#(
    parameter int         NUM_LINES = 32,
    parameter trig_mode_e LINE_MODE = TRIG_LATCH,
    localparam int        IDX_W     = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_stat,
    input logic                 wr_mask,
    input logic [NUM_LINES-1:0] status,
    input logic [NUM_LINES-1:0] mask,
    input logic                 irq_req,
    input logic                 pend_valid,
    input logic [IDX_W-1:0]     pend_idx
);
    logic [NUM_LINES-1:0] live;
    logic [NUM_LINES-1:0] below;
    assign live  = status & mask;
    assign below = (NUM_LINES'(1) << pend_idx) - NUM_LINES'(1);

    p_req_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == $past(|live));

    p_idx_lowest_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (live[pend_idx] && ((live & below) == '0)));

    p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_mask) |-> $stable(mask));

    if (LINE_MODE != TRIG_LEVEL) begin : g_hold
        p_status_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(wr_stat) |-> ((status & $past(status)) == $past(status)));
    end
endmodule

bind irq_ms_ctrl irq_ms_chk #(.NUM_LINES(NUM_LINES), .LINE_MODE(LINE_MODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat), .wr_mask(wr_mask),
    .status(status_w), .mask(mask_q), .irq_req(irq_req),
    .pend_valid(pend_valid), .pend_idx(pend_idx)
);

// File: tb/irq_ms_ctrl_test.sv
`timescale 1ns/1ps
module irq_ms_ctrl_test;
    import irq_ms_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rd_e, rd_v, rd_l;
    logic        req_e, req_v, req_l;
    logic        val_e, val_v, val_l;
    logic [4:0]  idx_e, idx_v, idx_l;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    // Edge capture, write-one clears
    irq_ms_ctrl #(.LINE_MODE(TRIG_EDGE), .CLEAR_ON_ZERO(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd_e),
        .irq_req(req_e), .pend_valid(val_e), .pend_idx(idx_e));
    // Pure level
    irq_ms_ctrl #(.LINE_MODE(TRIG_LEVEL), .CLEAR_ON_ZERO(1'b0)) uut_lvl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd_v),
        .irq_req(req_v), .pend_valid(val_v), .pend_idx(idx_v));
    // Latched level, write-zero clears
    irq_ms_ctrl #(.LINE_MODE(TRIG_LATCH), .CLEAR_ON_ZERO(1'b1)) uut_lat (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd_l),
        .irq_req(req_l), .pend_valid(val_l), .pend_idx(idx_l));

    // Scoreboard: unit 0 edge, 1 level, 2 latch; sig 0 mask, 1 status, 2 req, 3 valid, 4 idx
    typedef struct {
        string       tag;
        int          unit;
        int          sig;
        logic [31:0] exp;
    } exp_item_t;
    exp_item_t sb_q[$];

    task automatic push_exp(input string tag, input int unit, input int sig, input logic [31:0] exp);
        exp_item_t it;
        it.tag = tag; it.unit = unit; it.sig = sig; it.exp = exp;
        sb_q.push_back(it);
    endtask

    function automatic logic [31:0] observe(input int unit, input int sig);
        logic [31:0] rd;
        logic        rq, vl;
        logic [4:0]  ix;
        case (unit)
            0:       begin rd = rd_e; rq = req_e; vl = val_e; ix = idx_e; end
            1:       begin rd = rd_v; rq = req_v; vl = val_v; ix = idx_v; end
            default: begin rd = rd_l; rq = req_l; vl = val_l; ix = idx_l; end
        endcase
        case (sig)
            0, 1:    return rd;
            2:       return {31'd0, rq};
            3:       return {31'd0, vl};
            default: return {27'd0, ix};
        endcase
    endfunction

    // Monitor: pops and compares queued items at the current sampling point
    task automatic monitor_drain();
        logic        keep_addr;
        logic [31:0] got;
        keep_addr = reg_addr;
        while (sb_q.size() > 0) begin
            exp_item_t it;
            it = sb_q.pop_front();
            if (it.sig <= 1) reg_addr = it.sig[0];
            #1;
            got = observe(it.unit, it.sig);
            tests++;
            if (got !== it.exp) begin
                fails++;
                $display("FAIL %s unit%0d sig%0d: got %h expected %h", it.tag, it.unit, it.sig, got, it.exp);
            end
        end
        reg_addr = keep_addr;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        for (int u = 0; u < 3; u++) begin
            push_exp("R1 mask after reset", u, 0, 32'h0);
            push_exp("R1 status after reset", u, 1, 32'h0);
            push_exp("R1 req after reset", u, 2, 32'h0);
            push_exp("R1 valid after reset", u, 3, 32'h0);
        end
        monitor_drain();

        wr(ADDR_MASK, 32'hFFFF_FFFF);
        for (int u = 0; u < 3; u++) push_exp("R2 mask readback", u, 0, 32'hFFFF_FFFF);
        monitor_drain();

        // Line 5 rises just after a clock edge
        irq_in[5] = 1'b1;
        tick(2);
        push_exp("R3 edge not yet latched", 0, 1, 32'h0);
        push_exp("R3 latch not yet latched", 2, 1, 32'h0);
        push_exp("R5 level follows line", 1, 1, 32'h20);
        monitor_drain();
        tick(1);
        push_exp("R4 edge captured", 0, 1, 32'h20);
        push_exp("R6 level latched", 2, 1, 32'h20);
        push_exp("R10 level req after one clock", 1, 2, 32'h1);
        push_exp("R11 edge lowest index", 0, 4, 32'd5);
        push_exp("R11 edge valid", 0, 3, 32'h1);
        monitor_drain();
        tick(1);
        push_exp("R10 edge req", 0, 2, 32'h1);
        monitor_drain();

        irq_in[5] = 1'b0;
        tick(3);
        push_exp("R4 edge held after drop", 0, 1, 32'h20);
        push_exp("R6 latch held after drop", 2, 1, 32'h20);
        push_exp("R5 level drops", 1, 1, 32'h0);
        monitor_drain();

        wr(ADDR_STAT, 32'h0000_0020);
        push_exp("R7 one clears", 0, 1, 32'h0);
        push_exp("R8 one leaves", 2, 1, 32'h20);
        monitor_drain();
        wr(ADDR_STAT, 32'hFFFF_FFDF);
        push_exp("R8 zero clears", 2, 1, 32'h0);
        monitor_drain();

        // Line 9: clearing write lands on the capture edge
        irq_in[9] = 1'b1;
        tick(2);
        wr(ADDR_STAT, 32'h0000_0200);
        push_exp("R9 edge set beats clear", 0, 1, 32'h200);
        push_exp("R5 level ignores write", 1, 1, 32'h200);
        push_exp("R6 latch set", 2, 1, 32'h200);
        monitor_drain();
        wr(ADDR_STAT, 32'hFFFF_FDFF);
        push_exp("R7 zero leaves", 0, 1, 32'h200);
        push_exp("R9 latch high line beats clear", 2, 1, 32'h200);
        push_exp("R5 level ignores write", 1, 1, 32'h200);
        monitor_drain();

        irq_in[3] = 1'b1;
        tick(3);
        push_exp("R11 lowest of two", 0, 4, 32'd3);
        push_exp("R2 status shows all", 0, 1, 32'h208);
        monitor_drain();
        wr(ADDR_MASK, 32'hFFFF_FFF7);
        push_exp("R11 masked line skipped", 0, 4, 32'd9);
        push_exp("R11 masked line skipped", 2, 4, 32'd9);
        monitor_drain();
        wr(ADDR_MASK, 32'h0);
        push_exp("R11 valid off when masked", 0, 3, 32'h0);
        push_exp("R10 req still registered", 0, 2, 32'h1);
        monitor_drain();
        tick(1);
        for (int u = 0; u < 3; u++) push_exp("R10 req off after mask", u, 2, 32'h0);
        monitor_drain();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule